// File: doc/BRIEF.md
# Dual-Clock Capture FIFO with Memory-Mapped Read Port

This block buffers a stream of data words across two unrelated clocks. A producer in the write domain offers a word together with an enable. A processor in the read domain drains the buffer through a small memory-mapped slave. The slave has a read strobe, an output enable and a one-bit register select. Inside is an asynchronous FIFO. Its binary pointers are converted to Gray code and cross into the opposite domain through two-flop synchronizers. Full and empty are derived from those synchronized pointers, so both flags are conservative.

The read side works in show-ahead fashion. Whenever the buffer is not empty, the oldest word is already on the read-data bus. A bus read of the data register returns that word and removes it in the same access. A second register returns the empty flag, the full flag and the fill count as seen from the read domain. The block refuses pushes while full and pops while empty. One active-low reset clears both sides asynchronously, and its release is retimed separately in each clock domain.

Top module: `cdc_capture_fifo`

## Requirements
- R1: After reset, `rd_empty` is 1, `wr_full` is 0, and the status register reads 0x1.
- R2: A word is stored only on a write-clock edge where `prod_en` is 1 and `wr_full` is 0. A push offered while full is dropped and does not disturb stored words.
- R3: The head word is removed only on a read-clock edge where `bus_read` is 1, `out_en` is 1, `bus_addr` is 0 and `rd_empty` is 0. A read with `out_en` at 0, or a read of the status register, leaves the head in place.
- R4: While `rd_empty` is 0 and `bus_addr` is 0, `bus_readdata` shows the oldest unread word with no read strobe applied. A data read returns that word in the same access that removes it.
- R5: While `rd_empty` is 1, a data-register access returns 0, and a read strobe then moves no pointer. The next word pushed becomes the head.
- R6: `wr_full` rises once DEPTH words are stored and unread. It falls again after a word is popped and the read pointer has crossed into the write domain.
- R7: With `bus_addr` at 1, `bus_readdata` has the following layout:
  - bit 0 is empty;
  - bit 1 is full, meaning the read-side fill count equals DEPTH;
  - bits 2 and up hold the read-side fill count, log2(DEPTH)+1 bits wide;
  - all higher bits are 0.
- R8: With both clocks running and pushes and pops interleaved, words come out in the order accepted, each exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| rd_clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| prod_en | input | 1 | Producer offers a word this cycle |
| prod_data | input | DW | Word offered by the producer |
| wr_full | output | 1 | No room for another word (write-domain view) |
| bus_read | input | 1 | Slave read strobe |
| bus_addr | input | 1 | Register select: 0 data, 1 status |
| out_en | input | 1 | Permits a data read to pop |
| bus_readdata | output | DW | Head word or status word |
| rd_empty | output | 1 | No unread word (read-domain view) |

## Verification
A push and a pop can complete on overlapping edges, while the synchronized copy of one pointer still lags the real value. The streaming test makes this happen by running the producer and the reader at the same time. The producer writes on a 37 ns clock with random gaps, and the reader polls on a 10 ns clock and reads at random intervals, so the buffer hovers near empty. Every word the reader takes is compared against a reference queue filled at each accepted push. The test then checks that the queue drained exactly and that the buffer ends empty.

// File: rtl/cdcf_pkg.sv
package cdcf_pkg;
  localparam int ST_EMPTY   = 0;
  localparam int ST_FULL    = 1;
  localparam int ST_CNT_LSB = 2;

  typedef enum logic {
    REG_DATA   = 1'b0,
    REG_STATUS = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/cdcf_rst_sync.sv
module cdcf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= stage_d;
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/cdcf_ptr_sync.sv
module cdcf_ptr_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/cdcf_wr_side.sv
module cdcf_wr_side #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW:0]   rgray_sync,
  output logic          push,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          full
);
  localparam logic [AW:0] FULL_GAP = {1'b1, {AW{1'b0}}};

  logic [AW:0] wbin_q, wbin_d, wgray_q, wgray_d, rbin_s;

  always_comb begin
    rbin_s[AW] = rgray_sync[AW];
    for (int i = AW - 1; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rgray_sync[i];
  end

  always_comb begin
    full    = ((wbin_q - rbin_s) == FULL_GAP);
    push    = wr_en & ~full;
    wbin_d  = wbin_q + {{AW{1'b0}}, push};
    wgray_d = wbin_d ^ (wbin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (push) begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
    end
  end

  assign waddr = wbin_q[AW-1:0];
  assign wgray = wgray_q;
endmodule

// File: rtl/cdcf_rd_side.sv
module cdcf_rd_side #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop_req,
  input  logic [AW:0]   wgray_sync,
  output logic          pop,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic          empty,
  output logic [AW:0]   count
);
  logic [AW:0] rbin_q, rbin_d, rgray_q, rgray_d, wbin_s;

  always_comb begin
    wbin_s[AW] = wgray_sync[AW];
    for (int i = AW - 1; i >= 0; i--) wbin_s[i] = wbin_s[i+1] ^ wgray_sync[i];
  end

  always_comb begin
    count   = wbin_s - rbin_q;
    empty   = (count == '0);
    pop     = pop_req & ~empty;
    rbin_d  = rbin_q + {{AW{1'b0}}, pop};
    rgray_d = rbin_d ^ (rbin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else if (pop) begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
    end
  end

  assign raddr = rbin_q[AW-1:0];
  assign rgray = rgray_q;
endmodule

// File: rtl/cdc_capture_fifo.sv
module cdc_capture_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          prod_en,
  input  logic [DW-1:0] prod_data,
  output logic          wr_full,
  input  logic          bus_read,
  input  logic          bus_addr,
  input  logic          out_en,
  output logic [DW-1:0] bus_readdata,
  output logic          rd_empty
);
  import cdcf_pkg::*;

  localparam int          AW      = $clog2(DEPTH);
  localparam logic [AW:0] DEPTH_W = (AW+1)'(DEPTH);

  logic          wr_rst_n, rd_rst_n;
  logic          push, pop, pop_req;
  logic [AW-1:0] waddr, raddr;
  logic [AW:0]   wptr_gray, rptr_gray, wgray_sync, rgray_sync, rd_count;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] head, status_word;

  cdcf_rst_sync u_wrst (.clk(wr_clk), .arst_n(rst_n), .srst_n(wr_rst_n));
  cdcf_rst_sync u_rrst (.clk(rd_clk), .arst_n(rst_n), .srst_n(rd_rst_n));

  cdcf_ptr_sync #(.W(AW+1)) u_r2w (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rptr_gray), .q(rgray_sync));
  cdcf_ptr_sync #(.W(AW+1)) u_w2r (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wptr_gray), .q(wgray_sync));

  cdcf_wr_side #(.AW(AW)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .wr_en(prod_en), .rgray_sync(rgray_sync),
    .push(push), .waddr(waddr), .wgray(wptr_gray), .full(wr_full));

  assign pop_req = bus_read & out_en & (reg_sel_e'(bus_addr) == REG_DATA);

  cdcf_rd_side #(.AW(AW)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .pop_req(pop_req), .wgray_sync(wgray_sync),
    .pop(pop), .raddr(raddr), .rgray(rptr_gray), .empty(rd_empty),
    .count(rd_count));

  always_ff @(posedge wr_clk) begin
    if (push) mem[waddr] <= prod_data;
  end

  assign head = mem[raddr];

  always_comb begin
    status_word                      = '0;
    status_word[ST_EMPTY]            = rd_empty;
    status_word[ST_FULL]             = (rd_count == DEPTH_W);
    status_word[ST_CNT_LSB +: AW+1]  = rd_count;
    if (reg_sel_e'(bus_addr) == REG_STATUS) bus_readdata = status_word;
    else if (rd_empty)                      bus_readdata = '0;
    else                                    bus_readdata = head;
  end
endmodule

// File: rtl/cdcf_checker.sv
module cdcf_checker #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          wr_rst_n,
  input logic          rd_rst_n,
  input logic          wr_full,
  input logic          rd_empty,
  input logic [AW:0]   wptr_gray,
  input logic [AW:0]   rptr_gray,
  input logic [AW:0]   rd_count,
  input logic          bus_addr,
  input logic [DW-1:0] bus_readdata
);
  localparam logic [AW:0] DEPTH_W = {1'b1, {AW{1'b0}}};

  a_r2_no_overflow: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_full |=> $stable(wptr_gray));

  a_r3_no_underflow: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_empty |=> $stable(rptr_gray));

  a_r5_empty_reads_zero: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (!bus_addr && rd_empty) |-> (bus_readdata == '0));

  a_r7_count_bound: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_count <= DEPTH_W);

  // R8: pointers crossing domains change one bit at a time
  a_r8_wgray_step: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $countones(wptr_gray ^ $past(wptr_gray)) <= 1);

  a_r8_rgray_step: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $countones(rptr_gray ^ $past(rptr_gray)) <= 1);
endmodule

bind cdc_capture_fifo cdcf_checker #(.DW(DW), .AW(AW)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_rst_n(wr_rst_n), .rd_rst_n(rd_rst_n),
  .wr_full(wr_full), .rd_empty(rd_empty), .wptr_gray(wptr_gray),
  .rptr_gray(rptr_gray), .rd_count(rd_count), .bus_addr(bus_addr),
  .bus_readdata(bus_readdata));

// File: tb/cdc_capture_fifo_bench.sv
`timescale 1ns/100ps
module cdc_capture_fifo_bench;
  localparam int DW = 32;
  localparam int DEPTH = 16;

  logic wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
  logic prod_en = 1'b0, bus_read = 1'b0, bus_addr = 1'b0, out_en = 1'b0;
  logic [DW-1:0] prod_data = '0;
  logic [DW-1:0] bus_readdata;
  logic wr_full, rd_empty;

  int checks = 0, fails = 0;
  logic [DW-1:0] refq[$];

  always #18.5 wr_clk = ~wr_clk;
  always #5    rd_clk = ~rd_clk;

  cdc_capture_fifo #(.DW(DW), .DEPTH(DEPTH)) u_cdc_capture_fifo (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .prod_en(prod_en),
    .prod_data(prod_data), .wr_full(wr_full), .bus_read(bus_read),
    .bus_addr(bus_addr), .out_en(out_en), .bus_readdata(bus_readdata),
    .rd_empty(rd_empty));

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic settle_rd(); repeat (5) @(negedge rd_clk); endtask
  task automatic settle_wr(); repeat (4) @(negedge wr_clk); endtask

  task automatic push(input logic [DW-1:0] d);
    @(negedge wr_clk);
    if (!wr_full) refq.push_back(d);
    prod_en = 1'b1; prod_data = d;
    @(negedge wr_clk);
    prod_en = 1'b0;
  endtask

  task automatic peek(input logic a, output logic [DW-1:0] v);
    @(negedge rd_clk);
    bus_read = 1'b0; bus_addr = a; #1;
    v = bus_readdata;
  endtask

  task automatic bus_rd(input logic a, input logic oe, output logic [DW-1:0] v);
    @(negedge rd_clk);
    bus_addr = a; out_en = oe; bus_read = 1'b1; #1;
    v = bus_readdata;
    @(negedge rd_clk);
    bus_read = 1'b0; bus_addr = 1'b0;
  endtask

  function automatic logic [DW-1:0] status(input bit e, input bit f, input int n);
    return DW'(e) | (DW'(f) << 1) | (DW'(n) << 2);
  endfunction

  task automatic t_reset();
    logic [DW-1:0] v;
    chk("R1 empty", DW'(rd_empty), 1);
    chk("R1 full", DW'(wr_full), 0);
    peek(1'b1, v); chk("R1 status", v, status(1, 0, 0));
    peek(1'b0, v); chk("R5 data while empty", v, 0);
  endtask

  task automatic t_show_ahead();
    logic [DW-1:0] v;
    push(32'hA5A5_0001); settle_rd();
    chk("R4 not empty", DW'(rd_empty), 0);
    peek(1'b0, v); chk("R4 head visible", v, 32'hA5A5_0001);
    peek(1'b0, v); chk("R4 head held", v, 32'hA5A5_0001);
    bus_rd(1'b0, 1'b1, v); chk("R4 read returns head", v, refq.pop_front());
    peek(1'b0, v); chk("R4 popped, now zero", v, 0);
    chk("R4 empty after pop", DW'(rd_empty), 1);
  endtask

  task automatic t_gating();
    logic [DW-1:0] v;
    push(32'h0000_1111); push(32'h0000_2222); settle_rd();
    bus_rd(1'b0, 1'b0, v);
    peek(1'b0, v); chk("R3 out_en low keeps head", v, 32'h0000_1111);
    bus_rd(1'b1, 1'b1, v); chk("R7 status two words", v, status(0, 0, 2));
    peek(1'b0, v); chk("R3 status read keeps head", v, 32'h0000_1111);
    for (int i = 0; i < 2; i++) begin
      bus_rd(1'b0, 1'b1, v); chk("R3 drain", v, refq.pop_front());
    end
    peek(1'b1, v); chk("R7 status empty again", v, status(1, 0, 0));
  endtask

  task automatic t_empty_read();
    logic [DW-1:0] v;
    bus_rd(1'b0, 1'b1, v); chk("R5 empty read zero", v, 0);
    bus_rd(1'b0, 1'b1, v); chk("R5 second empty read zero", v, 0);
    push(32'h0000_0077); settle_rd();
    peek(1'b1, v); chk("R5 count one after push", v, status(0, 0, 1));
    bus_rd(1'b0, 1'b1, v); chk("R5 next push is head", v, refq.pop_front());
  endtask

  task automatic t_overflow();
    logic [DW-1:0] v;
    for (int i = 0; i < DEPTH + 3; i++) push(32'hC000_0000 + DW'(i));
    chk("R2 accepted count", DW'(refq.size()), DEPTH);
    chk("R6 full after DEPTH", DW'(wr_full), 1);
    settle_rd();
    peek(1'b1, v); chk("R7 status full", v, status(0, 1, DEPTH));
    bus_rd(1'b0, 1'b1, v); chk("R2 first word intact", v, refq.pop_front());
    settle_wr();
    chk("R6 full released", DW'(wr_full), 0);
    while (refq.size() > 0) begin
      bus_rd(1'b0, 1'b1, v); chk("R2 stored word intact", v, refq.pop_front());
    end
    settle_rd();
    chk("R2 no dropped word stored", DW'(rd_empty), 1);
  endtask

  task automatic t_stream();
    int got = 0;
    localparam int N = 60;
    fork
      begin
        for (int i = 0; i < N; i++) begin
          repeat ($urandom_range(0, 2)) @(negedge wr_clk);
          @(negedge wr_clk);
          while (wr_full) @(negedge wr_clk);
          refq.push_back(32'h5000_0000 + DW'(i));
          prod_en = 1'b1; prod_data = 32'h5000_0000 + DW'(i);
          @(negedge wr_clk);
          prod_en = 1'b0;
        end
      end
      begin
        while (got < N) begin
          @(negedge rd_clk);
          bus_read = 1'b0; bus_addr = 1'b0; out_en = 1'b1; #1;
          if (!rd_empty && ($urandom_range(0, 3) == 0)) begin
            bus_read = 1'b1;
            chk("R8 stream order", bus_readdata, refq.pop_front());
            got++;
          end
        end
        @(negedge rd_clk); bus_read = 1'b0;
      end
    join
    settle_rd();
    chk("R8 reference drained", DW'(refq.size()), 0);
    chk("R8 ends empty", DW'(rd_empty), 1);
  endtask

  initial begin
    repeat (3) @(negedge wr_clk);
    rst_n = 1'b1;
    settle_wr(); settle_rd();
    t_reset();
    t_show_ahead();
    t_gating();
    t_empty_read();
    t_overflow();
    t_stream();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge rd_clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule